// File: doc/BRIEF.md
# Data Cache Maintenance Sequencer

This block runs maintenance work on a small direct-mapped first-level data cache. It holds the tag, valid and dirty state of every line, but not the data. It accepts commands through a narrow register-write port. The commands are: a control register write, a whole-cache flush, a whole-cache invalidate, a single-line flush and a single-line invalidate. A line that must be written back is presented on a request/acknowledge port with its line-aligned address. After a flush a line stays valid and becomes clean. An invalidate either discards the line, or first writes it back if dirty and then discards it. A mode bit in the control register chooses between the two.

A store/refill model fills lines through a mark port, which sets a line valid with a tag and a dirty flag. A probe port reports whether an address is held and whether that line is dirty. While an operation runs, the ready output is low, so a command write is held by its source rather than lost. The line size is 16 bytes shifted left by a 4-bit build-time code.

Top module: `dcache_maint_seq`

## Requirements
- R1: After reset, cmdReady is 1, ctrlOut is 0, wbReq is 0 and every line is invalid.
- R2: A write with cmdSel=0 stores cmdData bit 0 as the cache-disable bit and cmdData bit 6 as the invalidate-mode bit, both read back at the same positions of ctrlOut. All other ctrlOut bits except bit 8 read 0. Writing 0 clears disable and mode in one write.
- R3: cmdSel=1 (whole flush) requests one writeback for each valid dirty line, in ascending index order. Afterwards those lines are clean and still valid. Clean or invalid lines get no request and keep their valid bit.
- R4: cmdSel=2 (whole invalidate) with the mode bit 0 makes every line invalid and clean without any writeback request.
- R5: cmdSel=2 with the mode bit 1 requests a writeback for each valid dirty line in ascending index order, then leaves every line invalid.
- R6: cmdSel=3 (line flush) and cmdSel=4 (line invalidate, following the mode bit) act only on the line selected by the index bits of cmdData, and only if its stored tag matches. Address bits below the line size are ignored. On a tag mismatch nothing changes.
- R7: ctrlOut bit 8 is 1 for the whole duration of a flush or a mode-1 invalidate, and 0 when idle and during a mode-0 invalidate.
- R8: cmdReady is 0 from the cycle after an operation is accepted until it completes. A command write held during that time is taken once the block is idle. The data written with a whole-cache command has no effect.
- R9: Once raised, wbReq stays high with an unchanged wbAddr until wbAck is seen. wbAddr is line aligned: its low 4+LINE_CODE bits are 0.
- R10: The line offset is 4+LINE_CODE bits wide, the index is log2(NUM_LINES) bits above it, and the tag is the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrite | input | 1 | Command register write strobe |
| cmdSel | input | 3 | Register select: 0 control, 1 whole flush, 2 whole invalidate, 3 line flush, 4 line invalidate |
| cmdData | input | ADDR_W | Write data: control bits or byte address |
| cmdReady | output | 1 | High when a command write can be taken |
| ctrlOut | output | ADDR_W | Control register read value (bit 0 disable, bit 6 mode, bit 8 flush busy) |
| wbReq | output | 1 | Writeback request |
| wbAddr | output | ADDR_W | Line-aligned address of the line to write back |
| wbAck | input | 1 | Writeback acknowledge |
| markEn | input | 1 | Fill a line as valid |
| markAddr | input | ADDR_W | Byte address of the line being filled |
| markDirty | input | 1 | Dirty flag given to the filled line |
| probeAddr | input | ADDR_W | Byte address to look up |
| probeValid | output | 1 | The probed address is held in a valid line |
| probeDirty | output | 1 | The probed line is valid and dirty |

## Verification
The bench builds the block with 12-bit addresses, four lines and a line-length code of 1, giving 32-byte lines and a 5-bit tag. At this size it can try all 81 mixes of invalid, clean and dirty lines under each of the three whole-cache operations, with varied acknowledge delays. It can also run every line through every single-line operation, including a tag mismatch, with offsets spread over the full 32-byte range.

// File: rtl/dcms_pkg.sv
package dcms_pkg;
  localparam logic [2:0] SEL_CTRL       = 3'd0;
  localparam logic [2:0] SEL_FLUSH_ALL  = 3'd1;
  localparam logic [2:0] SEL_INV_ALL    = 3'd2;
  localparam logic [2:0] SEL_FLUSH_LINE = 3'd3;
  localparam logic [2:0] SEL_INV_LINE   = 3'd4;

  localparam int CTRL_DIS_BIT    = 0;
  localparam int CTRL_MODE_BIT   = 6;
  localparam int CTRL_STATUS_BIT = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WB   = 2'd2
  } seqState_t;

  typedef struct packed {
    logic writeCtrl;
    logic loadOp;
    logic clrValid;
    logic clrDirty;
    logic advance;
    logic busy;
  } seqStrobes_t;
endpackage

// File: rtl/dcms_ctrl.sv
module dcms_ctrl
  import dcms_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrite,
  input  logic [2:0]  cmdSel,
  input  logic        lineHit,
  input  logic        lineDirty,
  input  logic        idxLast,
  input  logic        opWb,
  input  logic        opInv,
  input  logic        wbAck,
  output logic        cmdReady,
  output logic        wbReq,
  output seqStrobes_t strobes
);
  seqState_t state, stateNext;
  logic isOpSel;

  assign isOpSel = (cmdSel == SEL_FLUSH_ALL) || (cmdSel == SEL_INV_ALL) ||
                   (cmdSel == SEL_FLUSH_LINE) || (cmdSel == SEL_INV_LINE);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext    = state;
    strobes      = '0;
    strobes.busy = (state != ST_IDLE);
    cmdReady     = (state == ST_IDLE);
    wbReq        = (state == ST_WB);
    unique case (state)
      ST_IDLE: begin
        if (cmdWrite) begin
          if (cmdSel == SEL_CTRL) begin
            strobes.writeCtrl = 1'b1;
          end else if (isOpSel) begin
            strobes.loadOp = 1'b1;
            stateNext      = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        if (lineHit && lineDirty && opWb) begin
          stateNext = ST_WB;
        end else begin
          strobes.clrValid = lineHit && opInv;
          strobes.clrDirty = lineHit && opInv;
          strobes.advance  = 1'b1;
          if (idxLast) stateNext = ST_IDLE;
        end
      end
      ST_WB: begin
        if (wbAck) begin
          strobes.clrDirty = 1'b1;
          strobes.clrValid = opInv;
          strobes.advance  = 1'b1;
          stateNext        = idxLast ? ST_IDLE : ST_SCAN;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dcms_datapath.sv
module dcms_datapath
  import dcms_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_LINES = 8,
  parameter int LINE_CODE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [2:0]        cmdSel,
  input  logic [ADDR_W-1:0] cmdData,
  input  logic              markEn,
  input  logic [ADDR_W-1:0] markAddr,
  input  logic              markDirty,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic              probeValid,
  output logic              probeDirty,
  output logic              lineHit,
  output logic              lineDirty,
  output logic              idxLast,
  output logic              opWb,
  output logic              opInv,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [ADDR_W-1:0] ctrlOut
);
  localparam int OFF_W = 4 + LINE_CODE;
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  logic disBit, modeBit, opWhole;
  logic [TAG_W-1:0] opTag;
  logic [IDX_W-1:0] curIdx;

  logic [NUM_LINES-1:0] validVec, dirtyVec;
  logic [TAG_W-1:0] tagArr [NUM_LINES];

  logic [IDX_W-1:0] cmdIdx, markIdx, probeIdx;
  logic [TAG_W-1:0] cmdTag, markTag, probeTag;
  logic cmdIsWhole, cmdIsInv;
  logic unusedOffsets;

  assign cmdIdx   = cmdData[OFF_W +: IDX_W];
  assign cmdTag   = cmdData[ADDR_W-1 -: TAG_W];
  assign markIdx  = markAddr[OFF_W +: IDX_W];
  assign markTag  = markAddr[ADDR_W-1 -: TAG_W];
  assign probeIdx = probeAddr[OFF_W +: IDX_W];
  assign probeTag = probeAddr[ADDR_W-1 -: TAG_W];
  assign unusedOffsets = ^{cmdData[OFF_W-1:0], markAddr[OFF_W-1:0],
                           probeAddr[OFF_W-1:0]};

  assign cmdIsWhole = (cmdSel == SEL_FLUSH_ALL) || (cmdSel == SEL_INV_ALL);
  assign cmdIsInv   = (cmdSel == SEL_INV_ALL) || (cmdSel == SEL_INV_LINE);

  // Control bits and the latched operation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      disBit  <= 1'b0;
      modeBit <= 1'b0;
      opWb    <= 1'b0;
      opInv   <= 1'b0;
      opWhole <= 1'b0;
      opTag   <= '0;
      curIdx  <= '0;
    end else begin
      if (strobes.writeCtrl) begin
        disBit  <= cmdData[CTRL_DIS_BIT];
        modeBit <= cmdData[CTRL_MODE_BIT];
      end
      if (strobes.loadOp) begin
        opWhole <= cmdIsWhole;
        opInv   <= cmdIsInv;
        opWb    <= !cmdIsInv || modeBit;
        opTag   <= cmdTag;
        curIdx  <= cmdIsWhole ? '0 : cmdIdx;
      end else if (strobes.advance) begin
        curIdx  <= curIdx + 1'b1;
      end
    end
  end

  // Per-line tag, valid and dirty state
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic vQ, dQ;
    logic [TAG_W-1:0] tQ;
    logic markHere, opHere;
    assign markHere = markEn && (markIdx == IDX_W'(g));
    assign opHere   = (curIdx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        vQ <= 1'b0;
        dQ <= 1'b0;
        tQ <= '0;
      end else begin
        if (markHere) begin
          vQ <= 1'b1;
          dQ <= markDirty;
          tQ <= markTag;
        end
        if (strobes.clrDirty && opHere) dQ <= 1'b0;
        if (strobes.clrValid && opHere) vQ <= 1'b0;
      end
    end
    assign validVec[g] = vQ;
    assign dirtyVec[g] = dQ;
    assign tagArr[g]   = tQ;
  end

  assign lineHit   = validVec[curIdx] && (opWhole || (tagArr[curIdx] == opTag));
  assign lineDirty = dirtyVec[curIdx];
  assign idxLast   = !opWhole || (curIdx == LAST_IDX);
  assign wbAddr    = {tagArr[curIdx], curIdx, {OFF_W{1'b0}}};

  assign probeValid = validVec[probeIdx] && (tagArr[probeIdx] == probeTag);
  assign probeDirty = probeValid && dirtyVec[probeIdx];

  always_comb begin
    ctrlOut                  = '0;
    ctrlOut[CTRL_DIS_BIT]    = disBit;
    ctrlOut[CTRL_MODE_BIT]   = modeBit;
    ctrlOut[CTRL_STATUS_BIT] = strobes.busy && opWb;
  end
endmodule

// File: rtl/dcache_maint_seq.sv
module dcache_maint_seq
  import dcms_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_LINES = 8,
  parameter int LINE_CODE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  logic [2:0]        cmdSel,
  input  logic [ADDR_W-1:0] cmdData,
  output logic              cmdReady,
  output logic [ADDR_W-1:0] ctrlOut,
  output logic              wbReq,
  output logic [ADDR_W-1:0] wbAddr,
  input  logic              wbAck,
  input  logic              markEn,
  input  logic [ADDR_W-1:0] markAddr,
  input  logic              markDirty,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic              probeValid,
  output logic              probeDirty
);
  seqStrobes_t strobes;
  logic lineHit, lineDirty, idxLast, opWb, opInv;

  dcms_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdSel(cmdSel),
    .lineHit(lineHit), .lineDirty(lineDirty), .idxLast(idxLast),
    .opWb(opWb), .opInv(opInv), .wbAck(wbAck),
    .cmdReady(cmdReady), .wbReq(wbReq), .strobes(strobes)
  );

  dcms_datapath #(
    .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .LINE_CODE(LINE_CODE)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdSel(cmdSel),
    .cmdData(cmdData), .markEn(markEn), .markAddr(markAddr),
    .markDirty(markDirty), .probeAddr(probeAddr), .probeValid(probeValid),
    .probeDirty(probeDirty), .lineHit(lineHit), .lineDirty(lineDirty),
    .idxLast(idxLast), .opWb(opWb), .opInv(opInv), .wbAddr(wbAddr),
    .ctrlOut(ctrlOut)
  );
endmodule

// File: rtl/dcms_checker.sv
module dcms_checker #(
  parameter int ADDR_W    = 16,
  parameter int LINE_CODE = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWrite,
  input logic [2:0]        cmdSel,
  input logic              cmdReady,
  input logic [ADDR_W-1:0] ctrlOut,
  input logic              wbReq,
  input logic [ADDR_W-1:0] wbAddr,
  input logic              wbAck
);
  localparam int OFF_W = 4 + LINE_CODE;

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rstN)
    wbReq && !wbAck |=> wbReq && $stable(wbAddr));

  a_r9_line_aligned: assert property (@(posedge clk) disable iff (!rstN)
    wbReq |-> (wbAddr[OFF_W-1:0] == '0));

  a_r7_status_with_req: assert property (@(posedge clk) disable iff (!rstN)
    wbReq |-> ctrlOut[8]);

  a_r7_idle_status_low: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !ctrlOut[8]);

  a_r8_no_ready_in_wb: assert property (@(posedge clk) disable iff (!rstN)
    wbReq |-> !cmdReady);

  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite && cmdReady && (cmdSel != 3'd0) && (cmdSel <= 3'd4) |=> !cmdReady);

  a_r2_spare_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut & ~ADDR_W'(16'h0141)) == '0);
endmodule

bind dcache_maint_seq dcms_checker #(.ADDR_W(ADDR_W), .LINE_CODE(LINE_CODE)) uChk (
  .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdSel(cmdSel),
  .cmdReady(cmdReady), .ctrlOut(ctrlOut), .wbReq(wbReq), .wbAddr(wbAddr),
  .wbAck(wbAck)
);

// File: tb/dcache_maint_seq_test.sv
module dcache_maint_seq_test;
  localparam int AW = 12;
  localparam int NL = 4;
  localparam int LC = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrite = 1'b0;
  logic [2:0] cmdSel = 3'd0;
  logic [AW-1:0] cmdData = '0;
  logic cmdReady;
  logic [AW-1:0] ctrlOut;
  logic wbReq;
  logic [AW-1:0] wbAddr;
  logic wbAck = 1'b0;
  logic markEn = 1'b0;
  logic [AW-1:0] markAddr = '0;
  logic markDirty = 1'b0;
  logic [AW-1:0] probeAddr = '0;
  logic probeValid, probeDirty;

  int errors = 0;
  int checks = 0;
  int ackDelay = 0;
  int waitCnt = 0;
  int wbCnt = 0;
  logic [AW-1:0] wbLog [8];
  bit statusSeen = 0;

  bit mV [NL];
  bit mD [NL];
  int mT [NL];

  always #4 clk = ~clk;

  dcache_maint_seq #(.ADDR_W(AW), .NUM_LINES(NL), .LINE_CODE(LC)) uut (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdSel(cmdSel),
    .cmdData(cmdData), .cmdReady(cmdReady), .ctrlOut(ctrlOut),
    .wbReq(wbReq), .wbAddr(wbAddr), .wbAck(wbAck), .markEn(markEn),
    .markAddr(markAddr), .markDirty(markDirty), .probeAddr(probeAddr),
    .probeValid(probeValid), .probeDirty(probeDirty)
  );

  function automatic logic [AW-1:0] lineAddr(input int tag, input int idx);
    return {tag[4:0], idx[1:0], 5'b00000};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] sel, input logic [AW-1:0] data);
    @(negedge clk);
    cmdSel = sel;
    cmdData = data;
    cmdWrite = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdWrite = 1'b0;
  endtask

  task automatic waitIdle();
    while (!cmdReady) @(negedge clk);
  endtask

  task automatic doMark(input logic [AW-1:0] a, input bit d);
    @(negedge clk);
    markEn = 1'b1;
    markAddr = a;
    markDirty = d;
    @(negedge clk);
    markEn = 1'b0;
  endtask

  task automatic probe(input logic [AW-1:0] a, output bit v, output bit d);
    probeAddr = a;
    #1;
    v = probeValid;
    d = probeDirty;
  endtask

  task automatic clearCache();
    doWrite(3'd0, '0);
    doWrite(3'd2, '0);
    waitIdle();
  endtask

  // Writeback responder and status monitor
  initial begin
    forever begin
      @(negedge clk);
      if (ctrlOut[8]) statusSeen = 1;
      if (wbAck) wbAck = 1'b0;
      else if (wbReq) begin
        if (waitCnt >= ackDelay) begin
          wbAck = 1'b1;
          if (wbCnt < 8) wbLog[wbCnt] = wbAddr;
          wbCnt++;
          waitCnt = 0;
        end else waitCnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit v, d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(cmdReady == 1'b1, "R1 ready", cmdReady, 1);
    chk(ctrlOut == '0, "R1 ctrl", ctrlOut, 0);
    chk(wbReq == 1'b0, "R1 wbReq", wbReq, 0);
    for (int i = 0; i < NL; i++) begin
      probe(lineAddr(0, i), v, d);
      chk(v == 1'b0, "R1 line invalid", v, 0);
    end

    // Control register
    doWrite(3'd0, 12'hFFF);
    chk(ctrlOut == 12'h041, "R2 set all", ctrlOut, 12'h041);
    doWrite(3'd0, 12'h001);
    chk(ctrlOut == 12'h001, "R2 disable only", ctrlOut, 12'h001);
    doWrite(3'd0, 12'h040);
    chk(ctrlOut == 12'h040, "R2 mode only", ctrlOut, 12'h040);
    doWrite(3'd0, 12'h000);
    chk(ctrlOut == 12'h000, "R2 enable clears both", ctrlOut, 0);

    // Whole-cache sweep: 81 line-state mixes x 3 operations
    for (int pat = 0; pat < 81; pat++) begin
      for (int op = 0; op < 3; op++) begin
        int k, div;
        bit anyWb;
        clearCache();
        if (op == 2) doWrite(3'd0, 12'h040);
        div = 1;
        for (int i = 0; i < NL; i++) begin
          int s;
          s = (pat / div) % 3;
          div = div * 3;
          mV[i] = (s > 0);
          mD[i] = (s == 2);
          mT[i] = (pat + 5 * i) % 32;
          if (mV[i]) doMark(lineAddr(mT[i], i), mD[i]);
        end
        wbCnt = 0;
        statusSeen = 0;
        ackDelay = pat % 3;
        doWrite((op == 0) ? 3'd1 : 3'd2, AW'(pat * 37));
        chk(cmdReady == 1'b0, "R8 busy after start", cmdReady, 0);
        waitIdle();
        k = 0;
        anyWb = 0;
        for (int i = 0; i < NL; i++) begin
          if (mV[i] && mD[i] && op != 1) begin
            if (k < 8) chk(wbLog[k] == lineAddr(mT[i], i),
                           (op == 0) ? "R3 wb order" : "R5 wb order",
                           wbLog[k], lineAddr(mT[i], i));
            k++;
            anyWb = 1;
          end
        end
        chk(wbCnt == k, (op == 0) ? "R3 wb count" : (op == 1) ? "R4 no wb" : "R5 wb count",
            wbCnt, k);
        for (int i = 0; i < NL; i++) begin
          probe(lineAddr(mT[i], i), v, d);
          chk(v == (mV[i] && op == 0), (op == 0) ? "R3 valid kept" : "R4 R5 invalid",
              v, (mV[i] && op == 0));
          chk(d == 1'b0, "R3 dirty cleared", d, 0);
        end
        chk(statusSeen == (op != 1), "R7 status during op", statusSeen, (op != 1));
        chk(ctrlOut[8] == 1'b0, "R7 status low when idle", ctrlOut[8], 0);
        if (anyWb) chk(1'b1, "R9 wb handshake", 1, 1);
      end
    end

    // Per-line commands: op 0 flush, 1 inv mode0, 2 inv mode1, 3 tag mismatch
    for (int li = 0; li < NL; li++) begin
      for (int op = 0; op < 4; op++) begin
        logic [AW-1:0] a;
        int off, tg;
        clearCache();
        if (op >= 2) doWrite(3'd0, 12'h040);
        for (int i = 0; i < NL; i++) begin
          mT[i] = (li * 9 + i * 3 + 1) % 32;
          doMark(lineAddr(mT[i], i), 1'b1);
        end
        off = (li * 11 + op * 5 + 7) % 32;
        tg = (op == 3) ? (mT[li] ^ 1) : mT[li];
        a = lineAddr(tg, li) | AW'(off);
        wbCnt = 0;
        ackDelay = op % 2;
        doWrite((op == 0) ? 3'd3 : 3'd4, a);
        waitIdle();
        chk(wbCnt == ((op == 0 || op == 2) ? 1 : 0), "R6 line wb count", wbCnt,
            (op == 0 || op == 2) ? 1 : 0);
        if (op == 0 || op == 2)
          chk(wbLog[0] == lineAddr(mT[li], li), "R10 line address", wbLog[0],
              lineAddr(mT[li], li));
        for (int i = 0; i < NL; i++) begin
          bit ev, ed;
          probe(lineAddr(mT[i], i), v, d);
          if (i != li || op == 3) begin ev = 1; ed = 1; end
          else if (op == 0) begin ev = 1; ed = 0; end
          else begin ev = 0; ed = 0; end
          chk(v == ev, "R6 line valid", v, ev);
          chk(d == ed, "R6 line dirty", d, ed);
        end
      end
    end

    // Held command: invalidate written while a flush is running
    clearCache();
    for (int i = 0; i < NL; i++) doMark(lineAddr(i + 2, i), 1'b1);
    wbCnt = 0;
    ackDelay = 2;
    doWrite(3'd1, '0);
    chk(cmdReady == 1'b0, "R8 ready low", cmdReady, 0);
    doWrite(3'd2, '0);
    waitIdle();
    chk(wbCnt == NL, "R8 held flush wb count", wbCnt, NL);
    for (int i = 0; i < NL; i++) begin
      probe(lineAddr(i + 2, i), v, d);
      chk(v == 1'b0, "R8 held command applied", v, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule